// File: doc/BRIEF.md
# Level-2 Maskable Interrupt Aggregator

This block collects up to 32 interrupt sources and turns them into a single interrupt request for a CPU. A rising edge on any source line sets a sticky pending bit. Pending bits stay set until software clears them. A per-source enable mask decides which pending bits reach the combined request output.

Software never needs a read-modify-write on shared state. Pending bits are cleared by writing ones to a clear register. The mask is changed only through a dedicated mask-set register and a dedicated mask-clear register. Software can also raise pending bits itself through a write-one-to-set register. Typical bring-up has three steps: mask everything, clear everything, then unmask only the sources that are needed.

Top module: `irq_l2_agg`

## Requirements
- R1: After synchronous reset the pending register reads 0, every mask bit reads 1 (all sources disabled), and `irq_o` is 0.
- R2: A 0-to-1 transition on `src_i[n]` sets pending bit n on the clock edge that first samples the high level. A source held high does not set the bit again after it has been cleared.
- R3: A read at offset 0x00 returns the pending bits whether or not they are masked. Reads at offsets 0x04 and 0x08 return the same value.
- R4: Writing at offset 0x08 clears each pending bit whose `wdata` bit is 1 and leaves every other pending bit unchanged.
- R5: Writing at offset 0x04 sets each pending bit whose `wdata` bit is 1.
- R6: Writing at offset 0x10 sets each mask bit whose `wdata` bit is 1 (disables that source). Zero bits leave the mask unchanged.
- R7: Writing at offset 0x14 clears each mask bit whose `wdata` bit is 1 (enables that source). Zero bits leave the mask unchanged.
- R8: Reads at offsets 0x0C, 0x10 and 0x14 all return the current mask, where bit value 1 means masked.
- R9: `irq_o` is registered. It equals the OR of (pending AND NOT mask) as that state stood one clock earlier.
- R10: When a source edge and a clear of the same bit occur in the same cycle, the bit ends up set.
- R11: The sequence mask-set 0xFFFFFFFF, clear 0xFFFFFFFF, mask-clear 0x00000020 leaves only source 5 enabled. After it, only an event on source 5 raises `irq_o`.
- R12: `rdata` is registered. It is valid on the clock edge that samples `rd_en`. A read of any offset not named above returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt source lines, edge sensitive |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | NSRC | Write data, one bit per source |
| rdata | output | NSRC | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench first raises a single source while it is masked. This separates latching from reporting: the event must show in the pending register while `irq_o` stays low. It then holds that source high across a clear, which tells an edge latch apart from a level latch.

Next it runs the three-step bring-up with two sources active at once. Only the unmasked one may drive the output, and clearing it must drop the request even though the other bit is still pending. A software set followed by unmasking exercises the path that does not come from a source pin.

Finally, a source edge coinciding with a clear of that bit, mixed in the same write with a clear of another bit, shows which side wins and that neighbouring bits are unaffected.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;
  localparam int OFFS_W = 8;
  localparam logic [OFFS_W-1:0] OFS_PEND  = 8'h00;
  localparam logic [OFFS_W-1:0] OFS_SWSET = 8'h04;
  localparam logic [OFFS_W-1:0] OFS_CLR   = 8'h08;
  localparam logic [OFFS_W-1:0] OFS_MASK  = 8'h0C;
  localparam logic [OFFS_W-1:0] OFS_MSET  = 8'h10;
  localparam logic [OFFS_W-1:0] OFS_MCLR  = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK
  } rd_sel_e;
endpackage

// File: rtl/irq_l2_edge.sv
module irq_l2_edge #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] src_q;

  always_ff @(posedge clk) begin
    src_q <= src_i;
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_rise
      assign rise_o[g] = src_i[g] & ~src_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_l2_pend.sv
module irq_l2_pend #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] rise_i,
  input  logic [NSRC-1:0] swset_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q[g] <= 1'b0;
        end else if (rise_i[g] | swset_i[g]) begin
          pend_q[g] <= 1'b1;
        end else if (clr_i[g]) begin
          pend_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_l2_mask.sv
module irq_l2_mask #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] mset_i,
  input  logic [NSRC-1:0] mclr_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else begin
      mask_q <= (mask_q | mset_i) & ~mclr_i;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_l2_regif.sv
module irq_l2_regif
  import irq_l2_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] swset_o,
  output logic [NSRC-1:0] clr_o,
  output logic [NSRC-1:0] mset_o,
  output logic [NSRC-1:0] mclr_o,
  output logic [NSRC-1:0] rdata
);
  logic [OFFS_W-1:0] ofs;
  logic              hi_zero;
  rd_sel_e           sel;
  logic [NSRC-1:0]   rdata_q;

  generate
    if (AW > OFFS_W) begin : g_wide
      assign ofs     = addr[OFFS_W-1:0];
      assign hi_zero = (addr[AW-1:OFFS_W] == '0);
    end else begin : g_narrow
      assign ofs     = OFFS_W'(addr);
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    swset_o = '0;
    clr_o   = '0;
    mset_o  = '0;
    mclr_o  = '0;
    if (wr_en && hi_zero) begin
      unique case (ofs)
        OFS_SWSET: swset_o = wdata;
        OFS_CLR:   clr_o   = wdata;
        OFS_MSET:  mset_o  = wdata;
        OFS_MCLR:  mclr_o  = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    sel = SEL_NONE;
    if (hi_zero) begin
      unique case (ofs)
        OFS_PEND, OFS_SWSET, OFS_CLR: sel = SEL_PEND;
        OFS_MASK, OFS_MSET, OFS_MCLR: sel = SEL_MASK;
        default:                      sel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_PEND: rdata_q <= pend_i;
        SEL_MASK: rdata_q <= mask_i;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_l2_agg.sv
module irq_l2_agg #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_o
);
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] swset;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] mset;
  logic [NSRC-1:0] mclr;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] mask;
  logic            irq_q;

  irq_l2_edge #(.NSRC(NSRC)) u_edge (
    .clk    (clk),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irq_l2_regif #(.NSRC(NSRC), .AW(AW)) u_regif (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .pend_i  (pend),
    .mask_i  (mask),
    .swset_o (swset),
    .clr_o   (clr),
    .mset_o  (mset),
    .mclr_o  (mclr),
    .rdata   (rdata)
  );

  irq_l2_pend #(.NSRC(NSRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (rise),
    .swset_i (swset),
    .clr_i   (clr),
    .pend_o  (pend)
  );

  irq_l2_mask #(.NSRC(NSRC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .mset_i (mset),
    .mclr_i (mclr),
    .mask_o (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(pend & ~mask);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_l2_agg_chk.sv
module irq_l2_agg_chk
  import irq_l2_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_i,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NSRC-1:0] wdata,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask,
  input logic            irq_o
);
  logic [NSRC-1:0] src_d;
  logic [NSRC-1:0] ev;

  always_ff @(posedge clk) src_d <= src_i;
  assign ev = src_i & ~src_d;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mask == '1 && pend == '0 && !irq_o));

  assert_clear_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_CLR)) |=> ((pend & $past(wdata & ~ev)) == '0));

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_MSET)) |=> ((mask & $past(wdata)) == $past(wdata)));

  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_MCLR)) |=> ((mask & $past(wdata)) == '0));

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_CLR)) |=> ((pend & $past(ev)) == $past(ev)));

  assert_irq_combine_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(pend & ~mask))));
endmodule

bind irq_l2_agg irq_l2_agg_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .src_i (src_i),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .pend  (pend),
  .mask  (mask),
  .irq_o (irq_o)
);

// File: tb/irq_l2_agg_tb.sv
module irq_l2_agg_tb;
  localparam int NSRC = 32;
  localparam int AW   = 8;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic [NSRC-1:0] rdata;
  logic            irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [NSRC-1:0] exp;
    string           tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_l2_agg #(.NSRC(NSRC), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [NSRC-1:0] act,
                       input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the design returns it
  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (sb.size() == 0) begin
        check("scoreboard-empty", 1, 0);
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic reg_wr(input logic [AW-1:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_wr_src(input logic [AW-1:0] a, input logic [NSRC-1:0] d,
                            input logic [NSRC-1:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; src_i = s;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, input logic [NSRC-1:0] e,
                        input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [NSRC-1:0] s);
    @(negedge clk);
    src_i = s;
    @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string tag);
    @(negedge clk);
    @(negedge clk);
    check(tag, NSRC'(irq_o), NSRC'(e));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", NSRC'(irq_o), '0);
    reg_rd(8'h00, 32'h0000_0000, "R1 pending after reset");
    reg_rd(8'h0C, 32'hFFFF_FFFF, "R1 R8 mask after reset");

    // R2 R3: masked source edge latches, irq stays low
    set_src(32'h0000_0008);
    reg_rd(8'h00, 32'h0000_0008, "R2 R3 masked edge latched");
    check_irq(1'b0, "R9 masked pending gives no irq");
    // R2 R4: clear while level still high: no re-latch
    reg_wr(8'h08, 32'h0000_0008);
    reg_rd(8'h08, 32'h0000_0000, "R2 R4 held level not relatched");
    set_src(32'h0000_0000);

    // R11 bring-up sequence
    reg_wr(8'h10, 32'hFFFF_FFFF);
    reg_wr(8'h08, 32'hFFFF_FFFF);
    reg_wr(8'h14, 32'h0000_0020);
    reg_rd(8'h10, 32'hFFFF_FFDF, "R8 R11 mask via mask-set offset");
    reg_rd(8'h14, 32'hFFFF_FFDF, "R8 R7 mask via mask-clear offset");
    set_src(32'h0000_0080);
    check_irq(1'b0, "R11 masked source 7 no irq");
    set_src(32'h0000_00A0);
    reg_rd(8'h00, 32'h0000_00A0, "R3 both sources pending");
    check_irq(1'b1, "R11 R9 source 5 raises irq");
    reg_wr(8'h08, 32'h0000_0020);
    check_irq(1'b0, "R4 R9 clear source 5 drops irq");
    reg_rd(8'h04, 32'h0000_0080, "R4 R3 other bit untouched");

    // R5 software set, then unmask
    reg_wr(8'h04, 32'h0001_0000);
    reg_rd(8'h00, 32'h0001_0080, "R5 software set");
    check_irq(1'b0, "R9 software set still masked");
    reg_wr(8'h14, 32'h0001_0000);
    reg_rd(8'h0C, 32'hFFFE_FFDF, "R7 unmask bit 16");
    check_irq(1'b1, "R9 R7 unmasked software bit");
    reg_wr(8'h10, 32'h0001_0000);
    check_irq(1'b0, "R6 re-mask drops irq");
    reg_wr(8'h10, 32'h0000_0000);
    reg_rd(8'h0C, 32'hFFFF_FFDF, "R6 zero write to mask-set no change");
    reg_wr(8'h14, 32'h0000_0000);
    reg_rd(8'h0C, 32'hFFFF_FFDF, "R7 zero write to mask-clear no change");

    // R10: edge on bit 9 in the same cycle as its clear
    set_src(32'h0000_0000);
    reg_wr_src(8'h08, 32'h0001_0200, 32'h0000_0200);
    reg_rd(8'h00, 32'h0000_0280, "R10 event beats clear");

    // R12 unmapped offset
    reg_rd(8'h20, 32'h0000_0000, "R12 unmapped reads zero");
    reg_rd(8'h18, 32'h0000_0000, "R12 unmapped reads zero 0x18");

    repeat (3) @(negedge clk);
    check("scoreboard drained", NSRC'(sb.size()), '0);
    finish_run();
  end
endmodule